// File: doc/BRIEF.md
# Arbitrated Dual-Port Mailbox RAM

This block is a synchronous two-sided memory of 2048 eight-bit words. A left port and a right port each own a chip enable, a write select, an output enable, an address and separate write and read data buses, so two agents can read or write any word without coordinating with each other. Read data is registered. It appears one clock after the address.

When both ports target the same word in one cycle and at least one of them writes, an address comparator flags the right port as busy. That port's write is dropped, so the left port always wins. Two reads of one word are not a conflict. The two highest words act as mailboxes. Writing a word raises the interrupt flag on the opposite port, and that port clears the flag by reading the word.

A parameter sets the comparator mode. In master mode the comparator drives the busy outputs. In slave mode the busy inputs gate each port's writes, so several slices can share the decision of one master when they are ganged into a wider word.

Top module: `mbox_dpram`

## Requirements
- R1: After reset both interrupt flags are 0, both read data outputs are 0, and with idle inputs both busy outputs are 0.
- R2: A read (enable 1, write select 0, output enable 1) returns the word stored at that address on the read data output one clock later. Each port can read and write any address independently of the other.
- R3: A port whose enable is 0 does not write. A port that does not perform a read (enable 0, write select 1, or output enable 0) keeps its previous read data.
- R4: When both ports read the same address in one cycle, neither busy output asserts and both ports return the stored word.
- R5: In master mode, when both ports are enabled on the same address and at least one of them writes, the right busy output is 1 in that same cycle and the right port's write is dropped. The left busy output is never 1 in master mode, and a left write always lands.
- R6: In master mode, accesses to different addresses never raise either busy output.
- R7: An unblocked right-port write to address 0x7FF sets the left interrupt flag at the next clock. A left-port read of 0x7FF clears the flag at the next clock. If a set and a clear fall in the same cycle, the set wins.
- R8: An unblocked left-port write to address 0x7FE sets the right interrupt flag at the next clock. A right-port read of 0x7FE clears the flag at the next clock. If a set and a clear fall in the same cycle, the set wins.
- R9: In slave mode both busy outputs stay 0. A busy input at 1 drops that port's write in that cycle. A busy input at 0 lets the write land.
- R10: A read that collides with a write returns the word as it was before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write select (1 = write) |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | 11 | Left port address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port registered read data |
| l_busy_i | input | 1 | Left busy from a master (slave mode only) |
| l_busy_o | output | 1 | Left busy flag |
| l_irq | output | 1 | Left mailbox interrupt flag |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write select (1 = write) |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | 11 | Right port address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port registered read data |
| r_busy_i | input | 1 | Right busy from a master (slave mode only) |
| r_busy_o | output | 1 | Right busy flag |
| r_irq | output | 1 | Right mailbox interrupt flag |

## Verification
A comparator fault shows up in the same cycle as a busy output that disagrees with the two addresses and write selects. A wrong write gate stays hidden in the array until some later read of that word, so the bench reads back every location it has contended for.

A stuck or wrongly prioritised mailbox flag shows up one clock after the setting write or the clearing read. A read register that updates when it should hold shows up one clock after any read-free cycle. The bench compares both read outputs and both flags against its model after every edge.

// File: rtl/mbox_dpram_pkg.sv
package mbox_dpram_pkg;

   typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

   typedef struct packed {
      logic en;
      logic wr;
      logic oe;
   } port_ctl_t;

   function automatic logic is_rd_access(port_ctl_t c);
      return c.en && !c.wr;
   endfunction

   function automatic logic is_wr_access(port_ctl_t c);
      return c.en && c.wr;
   endfunction

endpackage

// File: rtl/mbox_dpram_arb.sv
module mbox_dpram_arb
   import mbox_dpram_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter bit MASTER = 1'b1
) (
   input  port_ctl_t [1:0]             ctl,
   input  logic      [1:0][ADDR_W-1:0] addr,
   input  logic      [1:0]             busy_in,
   output logic      [1:0]             busy_out,
   output logic      [1:0]             wr_block
);

   logic same_word;
   logic any_write;

   assign same_word = ctl[SIDE_L].en && ctl[SIDE_R].en && (addr[SIDE_L] == addr[SIDE_R]);
   assign any_write = ctl[SIDE_L].wr || ctl[SIDE_R].wr;

   generate
      if (MASTER) begin : g_master
         logic clash;
         assign clash              = same_word && any_write;
         assign busy_out[SIDE_L]   = 1'b0;
         assign busy_out[SIDE_R]   = clash;
         assign wr_block[SIDE_L]   = 1'b0;
         assign wr_block[SIDE_R]   = clash;
      end else begin : g_slave
         assign busy_out = '0;
         assign wr_block = busy_in;
      end
   endgenerate

endmodule

// File: rtl/mbox_dpram_store.sv
module mbox_dpram_store #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             rd_go,
   input  logic [1:0]             we,
   input  logic [1:0][ADDR_W-1:0] addr,
   input  logic [1:0][DATA_W-1:0] wdata,
   output logic [1:0][DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   // Right side is applied first so a left write to the same word lands last.
   always_ff @(posedge clk) begin
      for (int k = 1; k >= 0; k--) begin
         if (we[k]) cells[addr[k]] <= wdata[k];
      end
   end

   generate
      for (genvar s = 0; s < 2; s++) begin : g_rd
         logic [DATA_W-1:0] hold_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        hold_q <= '0;
            else if (rd_go[s]) hold_q <= cells[addr[s]];
         end
         assign rdata[s] = hold_q;
      end
   endgenerate

endmodule

// File: rtl/mbox_dpram_flag.sv
module mbox_dpram_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_req) flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
   end

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
   import mbox_dpram_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter bit MASTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              l_busy_i,
   output logic              l_busy_o,
   output logic              l_irq,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   input  logic              r_busy_i,
   output logic              r_busy_o,
   output logic              r_irq
);

   localparam int          DEPTH  = 1 << ADDR_W;
   localparam [ADDR_W-1:0] MBOX_L = ADDR_W'(DEPTH - 1);
   localparam [ADDR_W-1:0] MBOX_R = ADDR_W'(DEPTH - 2);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("mbox_dpram: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mbox_dpram: DATA_W must be at least 1");
      end
   endgenerate

   port_ctl_t [1:0]             ctl;
   logic      [1:0][ADDR_W-1:0] addr_v;
   logic      [1:0][DATA_W-1:0] wdata_v;
   logic      [1:0][DATA_W-1:0] rdata_v;
   logic      [1:0]             busy_in_v;
   logic      [1:0]             busy_out_v;
   logic      [1:0]             blk;
   logic      [1:0]             we;
   logic      [1:0]             rd_go;
   logic      [1:0]             irq_v;

   assign ctl[SIDE_L]       = '{en: l_en, wr: l_wr, oe: l_oe};
   assign ctl[SIDE_R]       = '{en: r_en, wr: r_wr, oe: r_oe};
   assign addr_v[SIDE_L]    = l_addr;
   assign addr_v[SIDE_R]    = r_addr;
   assign wdata_v[SIDE_L]   = l_wdata;
   assign wdata_v[SIDE_R]   = r_wdata;
   assign busy_in_v[SIDE_L] = l_busy_i;
   assign busy_in_v[SIDE_R] = r_busy_i;

   mbox_dpram_arb #(.ADDR_W(ADDR_W), .MASTER(MASTER)) u_arb (
      .ctl      (ctl),
      .addr     (addr_v),
      .busy_in  (busy_in_v),
      .busy_out (busy_out_v),
      .wr_block (blk)
   );

   generate
      for (genvar s = 0; s < 2; s++) begin : g_side
         localparam int          OTHER = 1 - s;
         localparam [ADDR_W-1:0] MBOX  = (s == 0) ? MBOX_L : MBOX_R;

         assign we[s]    = is_wr_access(ctl[s]) && !blk[s];
         assign rd_go[s] = is_rd_access(ctl[s]) && ctl[s].oe;

         mbox_dpram_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (we[OTHER] && (addr_v[OTHER] == MBOX)),
            .clr_req (is_rd_access(ctl[s]) && (addr_v[s] == MBOX)),
            .flag    (irq_v[s])
         );
      end
   endgenerate

   mbox_dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_go (rd_go),
      .we    (we),
      .addr  (addr_v),
      .wdata (wdata_v),
      .rdata (rdata_v)
   );

   assign l_rdata  = rdata_v[SIDE_L];
   assign r_rdata  = rdata_v[SIDE_R];
   assign l_busy_o = busy_out_v[SIDE_L];
   assign r_busy_o = busy_out_v[SIDE_R];
   assign l_irq    = irq_v[SIDE_L];
   assign r_irq    = irq_v[SIDE_R];

endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter bit MASTER = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_en,
   input logic              l_wr,
   input logic              l_oe,
   input logic [ADDR_W-1:0] l_addr,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_busy_o,
   input logic              l_irq,
   input logic              r_en,
   input logic              r_wr,
   input logic              r_oe,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_busy_o,
   input logic              r_irq
);

   localparam [ADDR_W-1:0] MB_L = {ADDR_W{1'b1}};
   localparam [ADDR_W-1:0] MB_R = {{(ADDR_W-1){1'b1}}, 1'b0};

   p_l_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_en && !l_wr && l_oe) |=> $stable(l_rdata));
   p_r_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(r_en && !r_wr && r_oe) |=> $stable(r_rdata));

   generate
      if (MASTER) begin : g_m
         p_left_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !l_busy_o);
         p_rr_no_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (l_en && r_en && !l_wr && !r_wr) |-> !r_busy_o);
         p_diff_no_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (l_addr != r_addr) |-> !r_busy_o);
         p_wr_clash_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (l_en && l_wr && r_en && l_addr == r_addr) |-> r_busy_o);
         p_l_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (l_en && !l_wr && l_addr == MB_L) |=> !l_irq);
         p_r_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (l_en && l_wr && l_addr == MB_R) |=> r_irq);
      end else begin : g_s
         p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !l_busy_o && !r_busy_o);
      end
   endgenerate

endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASTER(MASTER)) u_chk (.*);

// File: tb/sim_mbox_dpram.sv
module sim_mbox_dpram;

   localparam int LMB = 'h7FF;
   localparam int RMB = 'h7FE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic l_en = 0, l_wr = 0, l_oe = 0, l_bi = 0, r_en = 0, r_wr = 0, r_oe = 0, r_bi = 0;
   logic [10:0] l_addr = '0, r_addr = '0;
   logic [7:0]  l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
   logic l_busy_o, r_busy_o, l_irq, r_irq;

   logic s_len = 0, s_lwr = 0, s_lbi = 0, s_ren = 0, s_rwr = 0, s_rbi = 0;
   logic [10:0] s_la = '0, s_ra = '0;
   logic [7:0]  s_lwd = '0, s_rwd = '0, s_lrd, s_rrd;
   logic s_lbo, s_rbo, s_lirq, s_rirq;

   mbox_dpram #(.MASTER(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_rdata(l_rdata), .l_busy_i(l_bi), .l_busy_o(l_busy_o), .l_irq(l_irq),
      .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_rdata(r_rdata), .r_busy_i(r_bi), .r_busy_o(r_busy_o), .r_irq(r_irq));

   mbox_dpram #(.MASTER(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n),
      .l_en(s_len), .l_wr(s_lwr), .l_oe(1'b1), .l_addr(s_la), .l_wdata(s_lwd),
      .l_rdata(s_lrd), .l_busy_i(s_lbi), .l_busy_o(s_lbo), .l_irq(s_lirq),
      .r_en(s_ren), .r_wr(s_rwr), .r_oe(1'b1), .r_addr(s_ra), .r_wdata(s_rwd),
      .r_rdata(s_rrd), .r_busy_i(s_rbi), .r_busy_o(s_rbo), .r_irq(s_rirq));

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // behavioural reference state
   int mdl[int];
   int exp_l = 0, exp_r = 0;
   bit ok_l = 1, ok_r = 1;
   bit exp_li = 0, exp_ri = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input bit le, lw, lo, input int la, lwd,
                       input bit re, rw, ro, input int ra, rwd, input string tag);
      bit coll, rwok;
      l_en = le; l_wr = lw; l_oe = lo; l_addr = 11'(la); l_wdata = 8'(lwd);
      r_en = re; r_wr = rw; r_oe = ro; r_addr = 11'(ra); r_wdata = 8'(rwd);
      coll = le && re && (la == ra) && (lw || rw);
      #1;
      chk("R5 left busy", l_busy_o, 0);
      chk(coll ? "R5 right busy" : "R6 right busy", r_busy_o, coll);
      if (le && !lw && lo) begin
         ok_l = mdl.exists(la);
         if (ok_l) exp_l = mdl[la];
      end
      if (re && !rw && ro) begin
         ok_r = mdl.exists(ra);
         if (ok_r) exp_r = mdl[ra];
      end
      rwok = re && rw && !coll;
      if (rwok) mdl[ra] = rwd;
      if (le && lw) mdl[la] = lwd;
      if (rwok && ra == LMB) exp_li = 1;
      else if (le && !lw && la == LMB) exp_li = 0;
      if (le && lw && la == RMB) exp_ri = 1;
      else if (re && !rw && ra == RMB) exp_ri = 0;
      @(posedge clk); #1;
      if (ok_l) chk({tag, " left rdata"}, l_rdata, exp_l);
      if (ok_r) chk({tag, " right rdata"}, r_rdata, exp_r);
      chk("R7 left irq", l_irq, exp_li);
      chk("R8 right irq", r_irq, exp_ri);
      @(negedge clk);
   endtask

   task automatic sstep(input bit le, lw, input int la, lwd, input bit lbi,
                        input bit re, rw, input int ra, rwd, input bit rbi);
      s_len = le; s_lwr = lw; s_la = 11'(la); s_lwd = 8'(lwd); s_lbi = lbi;
      s_ren = re; s_rwr = rw; s_ra = 11'(ra); s_rwd = 8'(rwd); s_rbi = rbi;
      #1;
      chk("R9 slave left busy out", s_lbo, 0);
      chk("R9 slave right busy out", s_rbo, 0);
      @(posedge clk); #1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 left irq", l_irq, 0);
      chk("R1 right irq", r_irq, 0);
      chk("R1 left rdata", l_rdata, 0);
      chk("R1 right rdata", r_rdata, 0);
      chk("R1 left busy", l_busy_o, 0);
      chk("R1 right busy", r_busy_o, 0);

      // R2/R6: independent writes, then crossed reads
      step(1,1,1,'h010,'h5A, 1,1,1,'h020,'hC3, "R2");
      step(1,0,1,'h020,0,    1,0,1,'h010,0,    "R2");
      // R4: read/read of one word
      step(1,0,1,'h010,0,    1,0,1,'h010,0,    "R4");
      // R5: write/write clash, left wins
      step(1,1,1,'h030,'h11, 1,1,1,'h030,'h22, "R5");
      step(1,0,1,'h030,0,    1,0,1,'h030,0,    "R5");
      // R10: reads colliding with writes see old data
      step(1,0,1,'h010,0,    1,1,1,'h010,'h99, "R10");
      step(1,1,1,'h020,'h77, 1,0,1,'h020,0,    "R10");
      step(1,0,1,'h020,0,    1,0,1,'h010,0,    "R5");
      // R3: output enable low and disabled write
      step(1,0,0,'h030,0,    0,1,1,'h030,'hEE, "R3");
      step(0,1,1,'h020,'h01, 0,0,1,'h020,0,    "R3");
      step(1,0,1,'h030,0,    1,0,1,'h020,0,    "R3");
      // R7: right writes left mailbox, left reads clear it
      step(0,0,0,0,0,        1,1,1,LMB,'hA7,   "R7");
      step(0,0,0,0,0,        0,0,0,0,0,        "R7");
      step(1,0,1,LMB,0,      0,0,0,0,0,        "R7");
      // R8: left writes right mailbox, right reads clear it
      step(1,1,1,RMB,'hB8,   0,0,0,0,0,        "R8");
      step(0,0,0,0,0,        1,0,1,RMB,0,      "R8");
      // R8 set wins over clear in one cycle
      step(1,1,1,RMB,'hC9,   1,0,1,RMB,0,      "R8");
      step(0,0,0,0,0,        1,0,1,RMB,0,      "R8");

      // mixed traffic over a small address pool, checked every clock
      for (int i = 0; i < 400; i++) begin
         int pool[5] = '{'h010, 'h020, 'h030, RMB, LMB};
         step($urandom_range(0,5) != 0, $urandom_range(0,1), $urandom_range(0,3) != 0,
              pool[$urandom_range(0,4)], $urandom_range(0,255),
              $urandom_range(0,5) != 0, $urandom_range(0,1), $urandom_range(0,3) != 0,
              pool[$urandom_range(0,4)], $urandom_range(0,255), "R2");
      end
      step(0,0,0,0,0, 0,0,0,0,0, "R2");

      // R9: slave instance gated by busy inputs
      sstep(1,1,'h040,'h11,0, 1,1,'h041,'h44,0);
      sstep(1,1,'h040,'h22,1, 1,1,'h041,'h55,1);
      sstep(1,0,'h040,0,0,    1,0,'h041,0,0);
      chk("R9 blocked left write kept old word", s_lrd, 'h11);
      chk("R9 blocked right write kept old word", s_rrd, 'h44);
      sstep(1,1,'h040,'h66,0, 0,0,0,0,0);
      sstep(1,0,'h040,0,0,    0,0,0,0,0);
      chk("R9 ungated write lands", s_lrd, 'h66);

      finish_run();
   end

endmodule